// File: doc/BRIEF.md
# Conditional Fetch and Issue Front End

This block is the instruction front end of a processor that runs either 32-bit (wide) or 16-bit (narrow) instructions. It keeps a two-slot prefetch queue, holds the program counter, and issues one fetch per step to a memory that answers in the same cycle. Each step issues the oldest queued instruction together with an execute-enable and a 12-bit index into an external decode table. The queue then moves up one slot and the new fetch lands in the freed slot.

For wide instructions, the top nibble of the opcode is a condition code. This code is tested against the status flags. An instruction whose condition fails still uses its issue slot, but its execute-enable is low. The downstream units treat it as a no-op that costs only the step. A redirect flushes the queue and loads a new program counter. An injection port pushes a supplied opcode in front of the queue and rewinds the program counter by one instruction width, so that the program stream resumes unchanged afterwards.

Top module: `fe_fetch_gate`

## Requirements
- R1: While `rst` is high at a clock edge, the block drops `issue_valid` and `exec_en` to 0, sets the program counter to `RESET_PC` and empties the queue. After reset it refills the queue exactly as it does after a redirect.
- R2: After a redirect to address T, or after reset, the block makes two fill fetches. The first fetch is at T and loads slot 0. The second fetch is at T+w and loads slot 1. Here w is 4 for wide instructions and 2 for narrow ones. A `step` is ignored until both slots are filled, and no instruction issues during the fill.
- R3: With both slots full, a `step` issues slot 0 in the next cycle and moves slot 1 into slot 0. In the same cycle it fetches at the address that follows slot 1 into slot 1, and advances the program counter by w. The issued instructions therefore follow consecutive addresses.
- R4: Every `fetch_addr` is the raw address ANDed with `REGION_MASK`, so no bit outside the mask is ever set.
- R5: In the wide state the condition code is `issue_op[31:28]`. Code 0xE always executes and code 0xF never executes, whatever the flags.
- R6: The `flags` input is {N, Z, C, V}, with N in bit 3 and V in bit 0. Codes 0x0 to 0x7 execute on these conditions, in order: Z, not Z, C, not C, N, not N, V, not V.
- R7: Codes 0x8 to 0xD execute on these conditions, in order: C and not Z; not C or Z; N equal V; N not equal V; not Z and N equal V; Z or N not equal V.
- R8: An instruction whose condition fails still issues, with `issue_valid` high and `exec_en` low, and the queue still advances.
- R9: In the wide state `decode_idx` is {op[27:20], op[7:4]}.
- R10: In the narrow state the program counter moves by 2, `exec_en` is always 1, and `decode_idx` is {2'b00, op[15:6]}.
- R11: With both slots full, `inject` puts `inject_op` in slot 0, moves the old slot 0 into slot 1, rewinds the program counter by w and makes no fetch. The next two steps issue `inject_op` and then the old slot 0, and the sequential stream then continues.
- R12: `redirect` takes priority over `inject`, and `inject` takes priority over `step`. A cycle with `redirect` or `inject` issues nothing. A redirect discards both queued instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flags | input | 4 | Status flags {N, Z, C, V} |
| narrow_mode | input | 1 | 1 selects the 16-bit instruction state |
| step | input | 1 | Request to issue one instruction |
| redirect | input | 1 | Flush the queue and load a new program counter |
| redirect_pc | input | ADDR_W | New program counter |
| inject | input | 1 | Push `inject_op` in front of the queue |
| inject_op | input | 32 | Opcode to inject |
| fetch_data | input | 32 | Same-cycle read data for `fetch_addr` |
| fetch_req | output | 1 | A fetch is taken this cycle |
| fetch_addr | output | ADDR_W | Masked fetch address |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_op | output | 32 | Issued opcode |
| exec_en | output | 1 | The issued instruction is allowed to execute |
| decode_idx | output | 12 | Decode-table index of the issued opcode |

## Verification
The bench sweeps all sixteen condition codes under six flag patterns. Among these patterns are the cases where N and V differ, the cases where C and Z are both set, and the empty pattern. A swapped pair of codes or a wrong compound term would therefore let a suppressed instruction execute. Steps arrive during the two fill cycles after a redirect, and also in the same cycle as a redirect or an injection. A design that issued early would present stale queue contents or drop an instruction. Injection is tested in both states. It is followed by enough steps to show that a missing rewind would skip or repeat one program word. A redirect above the region mask and narrow-state runs catch masking errors, a wrong increment, and a wrong index slice.

// File: rtl/fe_pkg.sv
package fe_pkg;

    localparam int OP_W   = 32;
    localparam int IDX_W  = 12;
    localparam int CODE_W = 4;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_HALF  = 2'd1,
        FILL_FULL  = 2'd2
    } fill_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic            valid;
        logic            exec;
        logic [OP_W-1:0] op;
        logic [IDX_W-1:0] idx;
    } issue_t;

    function automatic logic cond_ok(input logic [CODE_W-1:0] code, input flags_t f);
        logic r;
        case (code)
            4'h0: r = f.z;
            4'h1: r = !f.z;
            4'h2: r = f.c;
            4'h3: r = !f.c;
            4'h4: r = f.n;
            4'h5: r = !f.n;
            4'h6: r = f.v;
            4'h7: r = !f.v;
            4'h8: r = f.c && !f.z;
            4'h9: r = !f.c || f.z;
            4'hA: r = (f.n == f.v);
            4'hB: r = (f.n != f.v);
            4'hC: r = !f.z && (f.n == f.v);
            4'hD: r = f.z || (f.n != f.v);
            4'hE: r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic [IDX_W-1:0] wide_index(input logic [OP_W-1:0] op);
        return {op[27:20], op[7:4]};
    endfunction

    function automatic logic [IDX_W-1:0] narrow_index(input logic [OP_W-1:0] op);
        return {2'b00, op[15:6]};
    endfunction

endpackage

// File: rtl/fe_cond_eval.sv
module fe_cond_eval
    import fe_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  flags_t          flags,
    input  logic            narrow,
    output logic            pass
);
    logic [CODE_W-1:0] code;

    assign code = op[OP_W-1 -: CODE_W];

    always_comb begin
        if (narrow) pass = 1'b1;
        else        pass = cond_ok(code, flags);
    end
endmodule

// File: rtl/fe_decode_index.sv
module fe_decode_index
    import fe_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    input  logic             narrow,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        if (narrow) idx = narrow_index(op);
        else        idx = wide_index(op);
    end
endmodule

// File: rtl/fe_prefetch_queue.sv
module fe_prefetch_queue
    import fe_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic            advance,
    input  logic            push_front,
    input  logic [OP_W-1:0] front_op,
    input  logic [OP_W-1:0] fill_data,
    output logic [OP_W-1:0] head,
    output fill_t           level
);
    logic [OP_W-1:0] slot0_q, slot1_q;
    fill_t           level_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            level_q <= FILL_EMPTY;
            if (rst) begin
                slot0_q <= '0;
                slot1_q <= '0;
            end
        end else begin
            case (level_q)
                FILL_EMPTY: begin
                    slot0_q <= fill_data;
                    level_q <= FILL_HALF;
                end
                FILL_HALF: begin
                    slot1_q <= fill_data;
                    level_q <= FILL_FULL;
                end
                default: begin
                    if (push_front) begin
                        slot1_q <= slot0_q;
                        slot0_q <= front_op;
                    end else if (advance) begin
                        slot0_q <= slot1_q;
                        slot1_q <= fill_data;
                    end
                end
            endcase
        end
    end

    assign head  = slot0_q;
    assign level = level_q;
endmodule

// File: rtl/fe_fetch_gate.sv
module fe_fetch_gate
    import fe_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] REGION_MASK = 32'h0000_0FFF,
    parameter logic [ADDR_W-1:0] RESET_PC    = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        flags,
    input  logic              narrow_mode,
    input  logic              step,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_pc,
    input  logic              inject,
    input  logic [31:0]       inject_op,
    input  logic [31:0]       fetch_data,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              issue_valid,
    output logic [31:0]       issue_op,
    output logic              exec_en,
    output logic [11:0]       decode_idx
);
    localparam logic [ADDR_W-1:0] WIDE_STEP   = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] NARROW_STEP = ADDR_W'(2);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] width;
    fill_t             level;
    logic [OP_W-1:0]   head;
    logic              full;
    logic              take_inject;
    logic              take_step;
    logic              pass;
    logic [IDX_W-1:0]  idx;
    issue_t            iss_q;

    assign width       = narrow_mode ? NARROW_STEP : WIDE_STEP;
    assign full        = (level == FILL_FULL);
    assign take_inject = !redirect && full && inject;
    assign take_step   = !redirect && full && !inject && step;

    assign fetch_req  = !redirect && (!full || take_step);
    assign fetch_addr = (pc_q + ((level == FILL_EMPTY) ? '0 : width)) & REGION_MASK;

    fe_prefetch_queue u_queue (
        .clk        (clk),
        .rst        (rst),
        .flush      (redirect),
        .advance    (take_step),
        .push_front (take_inject),
        .front_op   (inject_op),
        .fill_data  (fetch_data),
        .head       (head),
        .level      (level)
    );

    fe_cond_eval u_cond (
        .op     (head),
        .flags  (flags_t'(flags)),
        .narrow (narrow_mode),
        .pass   (pass)
    );

    fe_decode_index u_index (
        .op     (head),
        .narrow (narrow_mode),
        .idx    (idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_PC;
        end else if (redirect) begin
            pc_q <= redirect_pc;
        end else if (level == FILL_HALF) begin
            pc_q <= pc_q + width;
        end else if (take_inject) begin
            pc_q <= pc_q - width;
        end else if (take_step) begin
            pc_q <= pc_q + width;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            iss_q <= '0;
        end else begin
            iss_q.valid <= take_step;
            iss_q.exec  <= take_step && pass;
            if (take_step) begin
                iss_q.op  <= head;
                iss_q.idx <= idx;
            end
        end
    end

    assign issue_valid = iss_q.valid;
    assign exec_en     = iss_q.exec;
    assign issue_op    = iss_q.op;
    assign decode_idx  = iss_q.idx;
endmodule

// File: rtl/fe_fetch_gate_chk.sv
module fe_fetch_gate_chk #(
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] REGION_MASK = 32'h0000_0FFF
) (
    input logic              clk,
    input logic              rst,
    input logic              narrow_mode,
    input logic              redirect,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              issue_valid,
    input logic [31:0]       issue_op,
    input logic              exec_en,
    input logic [11:0]       decode_idx
);
    AST_EXEC_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (rst)
        exec_en |-> issue_valid); // R8

    AST_REDIRECT_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
        redirect |=> !issue_valid); // R12

    AST_FILL_GAP: assert property (@(posedge clk) disable iff (rst)
        $past(redirect) |=> !issue_valid); // R2

    AST_NARROW_EXEC: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && $past(narrow_mode)) |-> exec_en); // R10

    AST_CODE_F_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !$past(narrow_mode) && issue_op[31:28] == 4'hF) |-> !exec_en); // R5

    AST_CODE_E_RUNS: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !$past(narrow_mode) && issue_op[31:28] == 4'hE) |-> exec_en); // R5

    AST_WIDE_INDEX: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !$past(narrow_mode)) |-> decode_idx == {issue_op[27:20], issue_op[7:4]}); // R9

    AST_FETCH_MASKED: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> (fetch_addr & ~REGION_MASK) == '0); // R4
endmodule

bind fe_fetch_gate fe_fetch_gate_chk #(
    .ADDR_W      (ADDR_W),
    .REGION_MASK (REGION_MASK)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .narrow_mode (narrow_mode),
    .redirect    (redirect),
    .fetch_req   (fetch_req),
    .fetch_addr  (fetch_addr),
    .issue_valid (issue_valid),
    .issue_op    (issue_op),
    .exec_en     (exec_en),
    .decode_idx  (decode_idx)
);

// File: tb/fe_fetch_gate_tb.sv
module fe_fetch_gate_tb;
    localparam int          CLK_PERIOD = 10;
    localparam int          AW         = 32;
    localparam logic [31:0] MASK       = 32'h0000_0FFF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    flags = '0;
    logic          narrow_mode = 1'b0;
    logic          step = 1'b0;
    logic          redirect = 1'b0;
    logic [AW-1:0] redirect_pc = '0;
    logic          inject = 1'b0;
    logic [31:0]   inject_op = '0;
    logic [31:0]   fetch_data;
    logic          fetch_req;
    logic [AW-1:0] fetch_addr;
    logic          issue_valid;
    logic [31:0]   issue_op;
    logic          exec_en;
    logic [11:0]   decode_idx;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    // expected item: {tag[7:0], exec, op[31:0], idx[11:0]}
    logic [52:0] exp_q[$];
    logic [AW-1:0] next_addr;
    logic          inj_pending;
    logic [31:0]   inj_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    fe_fetch_gate #(.ADDR_W(AW), .REGION_MASK(MASK), .RESET_PC('0)) u_dut (
        .clk(clk), .rst(rst), .flags(flags), .narrow_mode(narrow_mode),
        .step(step), .redirect(redirect), .redirect_pc(redirect_pc),
        .inject(inject), .inject_op(inject_op), .fetch_data(fetch_data),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .issue_valid(issue_valid),
        .issue_op(issue_op), .exec_en(exec_en), .decode_idx(decode_idx)
    );

    function automatic logic [31:0] word_at(input logic [5:0] i);
        logic [27:0] body;
        body = 28'(i * 28'h9E3779B) ^ 28'h5A5A5A5;
        return {i[3:0], body};
    endfunction

    function automatic logic [15:0] half_at(input logic [5:0] i);
        return 16'(i * 16'h3B1D) ^ 16'hC0DE;
    endfunction

    function automatic logic [31:0] mem_read(input logic [AW-1:0] a, input logic nar);
        logic [AW-1:0] m;
        m = a & MASK;
        if (nar) return {16'h0, half_at(m[6:1])};
        return word_at(m[7:2]);
    endfunction

    assign fetch_data = mem_read(fetch_addr, narrow_mode);

    // independent condition model: codes pair up as (true, complement)
    function automatic logic model_cond(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v, base;
        n = f[3]; z = f[2]; cy = f[1]; v = f[0];
        case (c[3:1])
            3'd0: base = z;
            3'd1: base = cy;
            3'd2: base = n;
            3'd3: base = v;
            3'd4: base = cy & ~z;
            3'd5: base = ~(n ^ v);
            3'd6: base = ~z & ~(n ^ v);
            default: base = ~c[0];
        endcase
        return (c[3:1] == 3'd7) ? base : (base ^ c[0]);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // monitor: pops one expected item per issued instruction
    always @(negedge clk) begin
        if (!rst && issue_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R12 unexpected issue", {32'h0, issue_op}, 64'h0);
            end else begin
                logic [52:0] e;
                string rq;
                e = exp_q.pop_front();
                rq = $sformatf("R%0d", e[52:45]);
                check(issue_op == e[43:12], {rq, " op"}, {32'h0, issue_op}, {32'h0, e[43:12]});
                check(exec_en == e[44], {rq, " exec"}, {63'h0, exec_en}, {63'h0, e[44]});
                check(decode_idx == e[11:0], {rq, " R9/R10 idx"}, {52'h0, decode_idx}, {52'h0, e[11:0]});
            end
        end
    end

    task automatic do_redirect(input logic [AW-1:0] t, input logic nar);
        redirect = 1'b1; redirect_pc = t; narrow_mode = nar; step = 1'b1;
        tick();
        redirect = 1'b0; step = 1'b0;
        next_addr = t; inj_pending = 1'b0;
        check(fetch_addr == (t & MASK), "R2 R4 first fill addr", {32'h0, fetch_addr}, {32'h0, t & MASK});
        step = 1'b1;   // must be ignored during fill
        tick();
        check(fetch_addr == ((t + (nar ? 2 : 4)) & MASK), "R2 second fill addr",
              {32'h0, fetch_addr}, {32'h0, (t + (nar ? 2 : 4)) & MASK});
        tick();
        step = 1'b0;
        check(fetch_addr == ((t + (nar ? 4 : 8)) & MASK), "R3 full next fetch addr",
              {32'h0, fetch_addr}, {32'h0, (t + (nar ? 4 : 8)) & MASK});
    endtask

    task automatic do_step(input logic [3:0] f, input logic [7:0] tag);
        logic [31:0] op;
        logic        ex;
        logic [11:0] ix;
        if (inj_pending) begin
            op = inj_word; inj_pending = 1'b0;
        end else begin
            op = mem_read(next_addr, narrow_mode);
            next_addr = next_addr + (narrow_mode ? 2 : 4);
        end
        ex = narrow_mode ? 1'b1 : model_cond(op[31:28], f);
        ix = narrow_mode ? {2'b00, op[15:6]} : {op[27:20], op[7:4]};
        exp_q.push_back({tag, ex, op, ix});
        flags = f; step = 1'b1;
        tick();
        step = 1'b0;
    endtask

    task automatic do_inject(input logic [31:0] op, input logic with_step);
        inject = 1'b1; inject_op = op; step = with_step;
        tick();
        inject = 1'b0; step = 1'b0;
        inj_pending = 1'b1; inj_word = op;
        @(negedge clk);
        check(issue_valid == 1'b0, "R11 R12 no issue on inject", {63'h0, issue_valid}, 64'h0);
        #1;
    endtask

    initial begin
        logic [3:0] fset [6];
        fset[0] = 4'b0000; fset[1] = 4'b1111; fset[2] = 4'b0110;
        fset[3] = 4'b1001; fset[4] = 4'b1000; fset[5] = 4'b0010;
        next_addr = '0; inj_pending = 1'b0; inj_word = '0;

        tick(); tick();
        @(negedge clk);
        check(issue_valid == 1'b0 && exec_en == 1'b0, "R1 reset outputs", {62'h0, issue_valid, exec_en}, 64'h0);
        check(fetch_addr == 32'h0, "R1 reset pc", {32'h0, fetch_addr}, 64'h0);
        rst = 1'b0;
        step = 1'b1;   // ignored through the fill after reset
        tick(); tick();
        step = 1'b0;
        check(fetch_addr == 32'h8, "R1 R2 fill after reset", {32'h0, fetch_addr}, 64'h8);

        // R5 R6 R7 R8: every code under six flag patterns, wide state
        for (int s = 0; s < 6; s++)
            for (int k = 0; k < 16; k++)
                do_step(fset[s], (k < 8) ? 8'd6 : (k < 14) ? 8'd7 : 8'd5);
        for (int k = 0; k < 3; k++) do_step(4'b0100, 8'd8);

        // R4 R12: redirect above the region mask discards queued work
        do_redirect(32'hABCD_1230, 1'b0);
        for (int k = 0; k < 6; k++) do_step(4'b0101, 8'd3);

        // R11: inject a never-execute word, then an always-execute one
        do_inject(32'hF123_4567, 1'b1);
        for (int k = 0; k < 4; k++) do_step(4'b0000, 8'd11);
        do_inject(32'hE0AB_CDEF, 1'b0);
        for (int k = 0; k < 3; k++) do_step(4'b1100, 8'd11);

        // R10: narrow state
        do_redirect(32'h0000_0102, 1'b1);
        for (int k = 0; k < 10; k++) do_step(4'b0000, 8'd10);
        do_inject(32'h0000_9A5C, 1'b1);
        for (int k = 0; k < 4; k++) do_step(4'b1111, 8'd10);

        // R12: back to wide, redirect while stepping
        do_redirect(32'h0000_0040, 1'b0);
        for (int k = 0; k < 20; k++) do_step(4'(k), 8'd3);

        repeat (3) tick();
        check(exp_q.size() == 0, "R3 all expected issued", 64'(exp_q.size()), 64'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule